// File: doc/BRIEF.md
# Oversampling UART Receiver with Error Flags

This block turns an asynchronous NRZ receive line into parallel characters. A sampling enable pulses eight times per bit period. The line idles high. Each frame has a low start bit, 1 to `DW` data bits sent least significant bit first, an optional address/data marker bit, an optional parity bit, and one or two high stop bits. Character length, stop-bit count, parity enable and sense, and the address-bit mode are static configuration inputs. They must stay constant while a frame is in flight.

A completed character is placed in a holding buffer and a ready flag is raised. A one-cycle end-of-frame pulse and the captured address bit are exported for the wake-up logic that sits next to this block. The block records framing, parity, overrun and break conditions. It combines them into a single error flag and raises an interrupt request when the error interrupt enable input allows it. Reading the buffer is signalled by a one-cycle strobe. A synchronous software reset returns the receiver to idle and clears every flag, including break.

Top module: `oversampled_uart_rx`

## Requirements
- R1: After a falling edge, the start bit is accepted only if the line is sampled low on 4 consecutive sampling ticks. A shorter low pulse returns the receiver to idle, and no character results.
- R2: Each bit after the start bit takes the majority of its 4th, 5th and 6th samples of the 8 samples in the bit. Samples outside that window do not affect the value.
- R3: Data bits arrive least significant bit first. The character length is `cfg_len_m1`+1 bits. Bits of `rx_data` above the character length read 0.
- R4: When a frame completes, `frame_done` is high for exactly one clock, `rx_ready` is set, and the character and address bit are stored, unless the buffer is still full.
- R5: A `rd_strobe` pulse clears `rx_ready`, `rx_overrun`, `rx_frame_err` and `rx_par_err` on the next clock.
- R6: With `cfg_par_en`=1, a parity bit follows the data and address bits. The total count of ones over the data, address and parity bits must be even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. A mismatch sets `rx_par_err`.
- R7: A low first stop bit sets `rx_frame_err`. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: With `cfg_two_stop`=1, the second stop bit is not checked. A low level during the second stop bit neither sets an error nor starts a new frame.
- R9: If a frame completes while `rx_ready` is still set, `rx_overrun` is set and `rx_data` and `rx_addr` keep the earlier character.
- R10: If the line stays low for 10 bit periods (80 ticks) after a missing stop bit, `rx_break` is set. Only `sw_reset` clears it. A shorter low stretch leaves it clear.
- R11: `rx_err` is the OR of break, framing, overrun and parity errors. `err_irq` is `rx_err` gated by `err_irq_en`.
- R12: With `cfg_addr_mode`=1, one extra bit follows the data bits, ahead of any parity bit. Its value appears on `rx_addr`.
- R13: After `rst_n` or a `sw_reset` pulse, the receiver is idle with every flag clear, and `rx_data` is 0 after `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_reset | input | 1 | Synchronous software reset of receiver state and all flags |
| sample_tick | input | 1 | Sampling enable, 8 pulses per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len_m1 | input | $clog2(DW) | Character length minus one |
| cfg_two_stop | input | 1 | 1: two stop bits per frame |
| cfg_par_en | input | 1 | 1: a parity bit is present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_addr_mode | input | 1 | 1: an address/data marker bit is present |
| err_irq_en | input | 1 | Enables the error interrupt request |
| rd_strobe | input | 1 | One-cycle pulse: the buffer has been read |
| rx_data | output | DW | Received character |
| rx_addr | output | 1 | Address/data marker of the stored character |
| rx_ready | output | 1 | Buffer holds an unread character |
| frame_done | output | 1 | One-cycle end-of-frame event |
| rx_frame_err | output | 1 | Framing error |
| rx_par_err | output | 1 | Parity error |
| rx_overrun | output | 1 | Overrun error |
| rx_break | output | 1 | Break detected |
| rx_err | output | 1 | Combined error flag |
| err_irq | output | 1 | Error interrupt request |

## Verification
The line passes through two synchronizer flops. The sixth sample of the first stop bit is taken on a tick that falls 2 to 5 clocks after a bit-period point. The character, the flags and `frame_done` register on the clock of that tick. The effect of a read or a software reset appears one clock after its strobe. The break flag appears 80 ticks (320 clocks with a tick every 4 clocks) after the missing stop bit is decided. The bench drives every bit for exactly 32 clocks and follows each frame with two idle bit periods before it samples on a falling edge, so every registered result is settled when checked. Read and reset results are sampled one falling edge after the strobe. End-of-frame pulses are counted by a falling-edge monitor, and the checks compare that count against the number of frames expected, which exposes both spurious and missing frames.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_ADDR   = 3'd3,
        ST_PAR    = 3'd4,
        ST_STOP   = 3'd5,
        ST_GAP    = 3'd6,
        ST_WAITHI = 3'd7
    } rx_state_e;

endpackage

// File: rtl/ovs_rx_sampler.sv
// Two-flop synchronizer plus a sample history for the three-sample vote.
module ovs_rx_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd_in,
    output logic line,
    output logic vote
);

    typedef struct packed {
        logic [1:0] sync;
        logic [1:0] hist;
    } smp_regs_t;

    smp_regs_t q, d;

    always_comb begin
        d = q;
        d.sync = {q.sync[0], rxd_in};
        if (tick) begin
            d.hist = {q.hist[0], q.sync[1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign line = q.sync[1];
    // majority of the two previous samples and the one taken at this tick
    assign vote = (q.hist[1] & q.hist[0]) | (q.hist[1] & line) | (q.hist[0] & line);

endmodule

// File: rtl/ovs_rx_break.sv
// Counts low ticks after a missing stop bit and raises a sticky break flag.
module ovs_rx_break #(
    parameter int OVS      = 8,
    parameter int BRK_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic tick,
    input  logic line,
    output logic brk
);

    localparam int LIMIT = OVS * BRK_BITS;
    localparam int CW    = $clog2(LIMIT);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic          brk;
    } brk_regs_t;

    brk_regs_t q, d;

    always_comb begin
        d = q;
        if (arm) begin
            d.active = 1'b1;
            d.cnt    = '0;
        end else if (tick && q.active) begin
            if (line) begin
                d.active = 1'b0;
            end else if (q.cnt == CW'(LIMIT - 1)) begin
                d.brk    = 1'b1;
                d.active = 1'b0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
        if (clr) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign brk = q.brk;

endmodule

// File: rtl/oversampled_uart_rx.sv
module oversampled_uart_rx #(
    parameter int DW       = 8,
    parameter int OVS      = 8,
    parameter int BRK_BITS = 10,
    localparam int LW      = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_reset,
    input  logic          sample_tick,
    input  logic          rxd,
    input  logic [LW-1:0] cfg_len_m1,
    input  logic          cfg_two_stop,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_addr_mode,
    input  logic          err_irq_en,
    input  logic          rd_strobe,
    output logic [DW-1:0] rx_data,
    output logic          rx_addr,
    output logic          rx_ready,
    output logic          frame_done,
    output logic          rx_frame_err,
    output logic          rx_par_err,
    output logic          rx_overrun,
    output logic          rx_break,
    output logic          rx_err,
    output logic          err_irq
);
    import ovs_rx_pkg::*;

    localparam int PW        = $clog2(OVS);
    localparam int VOTE_IX   = OVS / 2 + 1;
    localparam int START_CHK = OVS / 2 - 1;

    typedef struct packed {
        rx_state_e     st;
        logic [PW-1:0] ph;
        logic [LW-1:0] bitn;
        logic [DW-1:0] shreg;
        logic          addr_s;
        logic          acc;
        logic [DW-1:0] data;
        logic          addr;
        logic          ready;
        logic          fe;
        logic          pe;
        logic          oe;
        logic          done;
    } rx_regs_t;

    rx_regs_t q, d;

    logic          rx_line;
    logic          rx_vote;
    logic          complete;
    logic          stop_ok;
    logic          ph_last;
    logic          at_vote;
    logic [PW-1:0] ph_nxt;
    rx_state_e     after_data;

    ovs_rx_sampler u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sample_tick),
        .rxd_in (rxd),
        .line   (rx_line),
        .vote   (rx_vote)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        complete = 1'b0;
        stop_ok  = 1'b1;
        ph_last  = (q.ph == PW'(OVS - 1));
        at_vote  = (q.ph == PW'(VOTE_IX));
        ph_nxt   = ph_last ? '0 : q.ph + PW'(1);
        if (cfg_addr_mode)   after_data = ST_ADDR;
        else if (cfg_par_en) after_data = ST_PAR;
        else                 after_data = ST_STOP;

        if (sample_tick) begin
            d.ph = ph_nxt;
            unique case (q.st)
                ST_IDLE: begin
                    d.ph = PW'(1);
                    if (!rx_line) d.st = ST_START;
                end
                ST_START: begin
                    if (q.ph <= PW'(START_CHK) && rx_line) begin
                        d.st = ST_IDLE;
                    end else if (ph_last) begin
                        d.st     = ST_DATA;
                        d.bitn   = '0;
                        d.shreg  = '0;
                        d.addr_s = 1'b0;
                        d.acc    = 1'b0;
                    end
                end
                ST_DATA: begin
                    if (at_vote) begin
                        d.shreg[q.bitn] = rx_vote;
                        d.acc           = q.acc ^ rx_vote;
                    end
                    if (ph_last) begin
                        if (q.bitn == cfg_len_m1) d.st = after_data;
                        else                      d.bitn = q.bitn + LW'(1);
                    end
                end
                ST_ADDR: begin
                    if (at_vote) begin
                        d.addr_s = rx_vote;
                        d.acc    = q.acc ^ rx_vote;
                    end
                    if (ph_last) d.st = cfg_par_en ? ST_PAR : ST_STOP;
                end
                ST_PAR: begin
                    if (at_vote) d.acc = q.acc ^ rx_vote;
                    if (ph_last) d.st = ST_STOP;
                end
                ST_STOP: begin
                    if (at_vote) begin
                        complete = 1'b1;
                        stop_ok  = rx_vote;
                        d.bitn   = '0;
                        if (!rx_vote)          d.st = ST_WAITHI;
                        else if (cfg_two_stop) d.st = ST_GAP;
                        else                   d.st = ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (ph_last) begin
                        if (q.bitn == LW'(1)) d.st = ST_IDLE;
                        else                  d.bitn = LW'(1);
                    end
                end
                ST_WAITHI: begin
                    if (rx_line) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end

        if (rd_strobe) begin
            d.ready = 1'b0;
            d.oe    = 1'b0;
            d.fe    = 1'b0;
            d.pe    = 1'b0;
        end

        if (complete) begin
            d.done = 1'b1;
            d.fe   = d.fe | !stop_ok;
            d.pe   = d.pe | (cfg_par_en & (q.acc ^ cfg_par_odd));
            if (d.ready) begin
                d.oe = 1'b1;
            end else begin
                d.ready = 1'b1;
                d.data  = q.shreg;
                d.addr  = q.addr_s;
            end
        end

        if (sw_reset) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    ovs_rx_break #(
        .OVS      (OVS),
        .BRK_BITS (BRK_BITS)
    ) u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_reset),
        .arm   (complete & !stop_ok & !sw_reset),
        .tick  (sample_tick),
        .line  (rx_line),
        .brk   (rx_break)
    );

    assign rx_data      = q.data;
    assign rx_addr      = q.addr;
    assign rx_ready     = q.ready;
    assign frame_done   = q.done;
    assign rx_frame_err = q.fe;
    assign rx_par_err   = q.pe;
    assign rx_overrun   = q.oe;
    assign rx_err       = rx_break | q.fe | q.oe | q.pe;
    assign err_irq      = rx_err & err_irq_en;

endmodule

// File: rtl/ovs_rx_chk.sv
module ovs_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_reset,
    input logic          rd_strobe,
    input logic [DW-1:0] rx_data,
    input logic          rx_ready,
    input logic          frame_done,
    input logic          rx_overrun,
    input logic          rx_break
);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R4
    done_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> rx_ready);

    // R5
    read_clears_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rx_overrun);

    // R5
    read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (frame_done || !rx_ready));

    // R9
    full_buffer_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_strobe && !sw_reset) |=> $stable(rx_data));

    // R10
    break_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !sw_reset) |=> rx_break);

    // R13
    swreset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!rx_ready && !rx_break && !rx_overrun));

endmodule

bind oversampled_uart_rx ovs_rx_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .rd_strobe  (rd_strobe),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .frame_done (frame_done),
    .rx_overrun (rx_overrun),
    .rx_break   (rx_break)
);

// File: tb/oversampled_uart_rx_tb.sv
`timescale 1ns/1ps
module oversampled_uart_rx_tb;

    localparam int BITCLK = 32;  // 8 ticks per bit, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] cfg_len_m1 = 3'd7;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_addr_mode = 1'b0;
    logic       err_irq_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_addr, rx_ready, frame_done, rx_frame_err, rx_par_err;
    logic       rx_overrun, rx_break, rx_err, err_irq;

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    int tdiv = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    oversampled_uart_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .sample_tick(sample_tick),
        .rxd(rxd), .cfg_len_m1(cfg_len_m1), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_addr_mode(cfg_addr_mode),
        .err_irq_en(err_irq_en), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_addr(rx_addr), .rx_ready(rx_ready), .frame_done(frame_done),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err), .rx_overrun(rx_overrun),
        .rx_break(rx_break), .rx_err(rx_err), .err_irq(err_irq)
    );

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        sample_tick = (tdiv == 0);
        if (frame_done === 1'b1) n_done++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input bit noisy);
        if (noisy && v) begin
            rxd = 1'b0; repeat (10) @(negedge clk);
            rxd = 1'b1; repeat (19) @(negedge clk);
            rxd = 1'b0; repeat (3)  @(negedge clk);
        end else begin
            rxd = v; repeat (BITCLK) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] data, input logic addr, input bit bad_par,
                              input logic stop1, input logic stop2, input bit noisy,
                              input int low_bits);
        logic par = 1'b0;
        drive_bit(1'b0, 0);
        for (int i = 0; i <= int'(cfg_len_m1); i++) begin
            drive_bit(data[i], noisy);
            par ^= data[i];
        end
        if (cfg_addr_mode) begin
            drive_bit(addr, 0);
            par ^= addr;
        end
        if (cfg_par_en) drive_bit(par ^ cfg_par_odd ^ logic'(bad_par), 0);
        drive_bit(stop1, 0);
        if (cfg_two_stop) drive_bit(stop2, 0);
        if (low_bits > 0) begin
            rxd = 1'b0;
            repeat (low_bits * BITCLK) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic do_swreset();
        sw_reset = 1'b1; @(negedge clk); sw_reset = 1'b0;
    endtask

    task automatic t_reset();
        chk("R13 ready after reset", rx_ready, 0);
        chk("R13 data after reset", rx_data, 0);
        chk("R13 err after reset", rx_err, 0);
        chk("R13 break after reset", rx_break, 0);
    endtask

    task automatic t_basic();
        int n0 = n_done;
        send_frame(8'hA5, 0, 0, 1, 1, 0, 0);
        chk("R4 one frame", n_done - n0, 1);
        chk("R4 ready", rx_ready, 1);
        chk("R3 data 8 bits", rx_data, 8'hA5);
        chk("R11 no error", rx_err, 0);
        do_read();
        chk("R5 ready cleared", rx_ready, 0);
    endtask

    task automatic t_length();
        cfg_len_m1 = 3'd4;
        send_frame(8'hF3, 0, 0, 1, 1, 0, 0);
        chk("R3 data 5 bits", rx_data, 8'h13);
        do_read();
        cfg_len_m1 = 3'd0;
        send_frame(8'h01, 0, 0, 1, 1, 0, 0);
        chk("R3 data 1 bit", rx_data, 8'h01);
        chk("R3 no framing on 1 bit", rx_frame_err, 0);
        do_read();
        cfg_len_m1 = 3'd7;
    endtask

    task automatic t_glitch();
        int n0 = n_done;
        rxd = 1'b0; repeat (8) @(negedge clk);
        rxd = 1'b1; repeat (3 * BITCLK) @(negedge clk);
        chk("R1 glitch gives no frame", n_done - n0, 0);
        chk("R1 glitch leaves ready clear", rx_ready, 0);
        send_frame(8'h3C, 0, 0, 1, 1, 0, 0);
        chk("R1 next frame after glitch", rx_data, 8'h3C);
        do_read();
    endtask

    task automatic t_noise();
        send_frame(8'hFF, 0, 0, 1, 1, 1, 0);
        chk("R2 vote ignores edge samples", rx_data, 8'hFF);
        do_read();
        send_frame(8'h5A, 0, 0, 1, 1, 1, 0);
        chk("R2 vote mixed bits", rx_data, 8'h5A);
        do_read();
    endtask

    task automatic t_parity();
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0; err_irq_en = 1'b0;
        send_frame(8'h3C, 0, 0, 1, 1, 0, 0);
        chk("R6 even good", rx_par_err, 0);
        do_read();
        send_frame(8'h3C, 0, 1, 1, 1, 0, 0);
        chk("R6 even bad", rx_par_err, 1);
        chk("R11 err from parity", rx_err, 1);
        chk("R11 irq gated off", err_irq, 0);
        err_irq_en = 1'b1; #1;
        chk("R11 irq enabled", err_irq, 1);
        do_read();
        chk("R5 parity cleared", rx_par_err, 0);
        chk("R11 irq drops", err_irq, 0);
        cfg_par_odd = 1'b1;
        send_frame(8'h07, 0, 0, 1, 1, 0, 0);
        chk("R6 odd good", rx_par_err, 0);
        do_read();
        send_frame(8'h07, 0, 1, 1, 1, 0, 0);
        chk("R6 odd bad", rx_par_err, 1);
        do_read();
        err_irq_en = 1'b0; cfg_par_odd = 1'b0; cfg_par_en = 1'b0;
    endtask

    task automatic t_addr();
        cfg_addr_mode = 1'b1;
        send_frame(8'h42, 1, 0, 1, 1, 0, 0);
        chk("R12 addr bit set", rx_addr, 1);
        chk("R12 data with addr", rx_data, 8'h42);
        do_read();
        cfg_par_en = 1'b1;
        send_frame(8'h01, 1, 0, 1, 1, 0, 0);
        chk("R12 addr in parity", rx_par_err, 0);
        chk("R12 addr bit again", rx_addr, 1);
        do_read();
        send_frame(8'h81, 0, 0, 1, 1, 0, 0);
        chk("R12 addr bit clear", rx_addr, 0);
        do_read();
        cfg_par_en = 1'b0; cfg_addr_mode = 1'b0;
    endtask

    task automatic t_overrun();
        int n0 = n_done;
        send_frame(8'h11, 0, 0, 1, 1, 0, 0);
        send_frame(8'h22, 0, 0, 1, 1, 0, 0);
        chk("R9 two frames", n_done - n0, 2);
        chk("R9 overrun set", rx_overrun, 1);
        chk("R9 old data kept", rx_data, 8'h11);
        do_read();
        chk("R5 overrun cleared", rx_overrun, 0);
        chk("R5 ready cleared", rx_ready, 0);
    endtask

    task automatic t_framing();
        send_frame(8'h5A, 0, 0, 0, 1, 0, 0);
        chk("R7 framing set", rx_frame_err, 1);
        chk("R7 data stored", rx_data, 8'h5A);
        chk("R10 no break on short low", rx_break, 0);
        do_read();
        chk("R5 framing cleared", rx_frame_err, 0);
        send_frame(8'h00, 0, 0, 0, 1, 0, 5);
        chk("R10 no break after 5 low bits", rx_break, 0);
        chk("R7 framing again", rx_frame_err, 1);
        do_read();
    endtask

    task automatic t_two_stop();
        int n0 = n_done;
        cfg_two_stop = 1'b1;
        send_frame(8'h96, 0, 0, 1, 0, 0, 0);
        chk("R8 one frame only", n_done - n0, 1);
        chk("R8 second stop not checked", rx_frame_err, 0);
        chk("R8 data", rx_data, 8'h96);
        do_read();
        cfg_two_stop = 1'b0;
    endtask

    task automatic t_break();
        send_frame(8'h00, 0, 0, 0, 1, 0, 12);
        chk("R10 break set", rx_break, 1);
        chk("R11 err from break", rx_err, 1);
        do_read();
        chk("R10 break survives read", rx_break, 1);
        do_swreset();
        chk("R10 break cleared by sw_reset", rx_break, 0);
        chk("R13 err clear after sw_reset", rx_err, 0);
        send_frame(8'hC3, 0, 0, 1, 1, 0, 0);
        chk("R13 receive after sw_reset", rx_data, 8'hC3);
        do_read();
    endtask

    task automatic t_swreset();
        send_frame(8'h77, 0, 0, 0, 1, 0, 0);
        do_swreset();
        chk("R13 ready cleared", rx_ready, 0);
        chk("R13 framing cleared", rx_frame_err, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        t_reset();
        t_basic();
        t_length();
        t_glitch();
        t_noise();
        t_parity();
        t_addr();
        t_overrun();
        t_framing();
        t_two_stop();
        t_break();
        t_swreset();
        finish_run();
    end

endmodule